// File: doc/BRIEF.md
# Stereo Sample Attenuator

This block scales a stereo stream of signed PCM samples. Each channel has its own 14-bit linear volume code, held in a register. Two shared controls can flip the output polarity or silence both channels. A sample goes in with a valid strobe and comes out two clock edges later with its own valid strobe. The left and right lanes run independently, so their strobes need not coincide.

The settings are registers loaded through write strobes. After reset, both volumes sit at full scale, and polarity flip and mute are both off. A sample takes the settings that are registered on the clock edge where it is accepted. A later write therefore never alters a sample that is already in the pipeline, so a gain change always falls between samples.

Top module: `stereo_attenuator`

## Requirements
- R1: A sample accepted on edge k (valid high) is presented with its output valid high after edge k+2 for exactly one cycle. The output valid is low whenever no sample was accepted two edges earlier, and each lane's timing is independent of the other.
- R2: With the multiplier m equal to the volume code v (0 to 16382), the output is floor((x*m + 8192) / 16384), where x is the 24-bit two's complement input. This gives rounding half toward positive infinity.
- R3: Volume code 16383 uses m = 16384, so the input passes through bit-exact.
- R4: Volume code 0 yields an output of 0 for every input.
- R5: cfg_vol_we bit 0 loads cfg_vol into the left volume and bit 1 loads it into the right. A write to one channel leaves the other channel's volume unchanged.
- R6: After reset, both volumes are 16383, polarity flip is off, mute is off, and both output valids are low.
- R7: With cfg_invert stored as 1 (via cfg_mode_we), the scaled result is negated. The scaled value -8388608 saturates to +8388607.
- R8: With cfg_mute stored as 1, both outputs are 0 regardless of volume and polarity flip.
- R9: A sample uses the settings registered before its accepting edge. A write on that same edge applies only to later samples, and a write while the sample is in flight does not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_vol_we | input | 2 | Volume load strobes: bit 0 left, bit 1 right |
| cfg_vol | input | 14 | Volume code to load |
| cfg_mode_we | input | 1 | Loads the polarity and mute settings |
| cfg_invert | input | 1 | Polarity flip value to load |
| cfg_mute | input | 1 | Mute value to load |
| l_valid | input | 1 | Left input sample strobe |
| l_data | input | 24 | Left input sample, two's complement |
| r_valid | input | 1 | Right input sample strobe |
| r_data | input | 24 | Right input sample, two's complement |
| l_out_valid | output | 1 | Left output strobe |
| l_out | output | 24 | Left scaled sample |
| r_out_valid | output | 1 | Right output strobe |
| r_out | output | 24 | Right scaled sample |

## Verification
A settings write can land on the same edge as a sample being accepted, or while that sample is still inside the pipeline. The bench provokes both cases. It raises a volume write together with a sample strobe, and it raises a mute write one cycle after a sample. It then judges the output against the setting that was registered before the sample's edge, not the new one. The polarity flip and the most negative input also meet in the full sweep, where the saturated result is compared with a value computed independently.

// File: rtl/gain_pkg.sv
package gain_pkg;
   typedef struct packed {
      logic invert;
      logic mute;
   } mode_t;

   localparam mode_t MODE_RESET = '{invert: 1'b0, mute: 1'b0};
endpackage

// File: rtl/gain_cfg_regs.sv
module gain_cfg_regs
   import gain_pkg::*;
#(
   parameter int VOL_W  = 14,
   parameter int NUM_CH = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_CH-1:0]              vol_we,
   input  logic [VOL_W-1:0]               vol_din,
   input  logic                           mode_we,
   input  mode_t                          mode_din,
   output logic [NUM_CH-1:0][VOL_W-1:0]   vol_q,
   output mode_t                          mode_q
);
   localparam logic [VOL_W-1:0] VOL_RESET = {VOL_W{1'b1}};

   for (genvar c = 0; c < NUM_CH; c++) begin : g_vol
      always_ff @(posedge clk) begin
         if (!rst_n)
            vol_q[c] <= VOL_RESET;
         else if (vol_we[c])
            vol_q[c] <= vol_din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= MODE_RESET;
      else if (mode_we)
         mode_q <= mode_din;
   end
endmodule

// File: rtl/sat_negate.sv
module sat_negate #(
   parameter int W = 24
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

   always_comb begin
      if (din == MOST_NEG)
         dout = MOST_POS;
      else
         dout = (~din) + {{(W-1){1'b0}}, 1'b1};
   end
endmodule

// File: rtl/gain_lane.sv
module gain_lane
   import gain_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int VOL_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [VOL_W-1:0]  vol,
   input  mode_t             mode,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   localparam int MW = VOL_W + 1;
   localparam int PW = DATA_W + MW + 1;
   localparam logic [VOL_W-1:0] FULL_CODE = {VOL_W{1'b1}};
   localparam logic [MW-1:0]    UNITY     = {1'b1, {VOL_W{1'b0}}};
   localparam logic [PW-1:0]    HALF_LSB  = {{(PW-VOL_W){1'b0}}, 1'b1, {(VOL_W-1){1'b0}}};

   // stage 1: multiply with the settings held at the accepting edge
   logic [MW-1:0]        mult;
   logic signed [PW-1:0] a_ext, b_ext, prod_c, prod_q;
   logic                 v1;
   mode_t                mode1;

   always_comb begin
      mult   = (vol == FULL_CODE) ? UNITY : {1'b0, vol};
      a_ext  = {{(PW-DATA_W){in_data[DATA_W-1]}}, in_data};
      b_ext  = {{(PW-MW){1'b0}}, mult};
      prod_c = a_ext * b_ext;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1     <= 1'b0;
         prod_q <= '0;
         mode1  <= MODE_RESET;
      end else begin
         v1 <= in_valid;
         if (in_valid) begin
            prod_q <= prod_c;
            mode1  <= mode;
         end
      end
   end

   // stage 2: round, optional negate, mute
   logic [PW-1:0]     rounded;
   logic [DATA_W-1:0] scaled, negated, result;
   logic              lane_unused;

   always_comb begin
      rounded = prod_q + HALF_LSB;
      scaled  = rounded[VOL_W +: DATA_W];
   end
   assign lane_unused = ^{rounded[VOL_W-1:0], rounded[PW-1:VOL_W+DATA_W]};

   sat_negate #(.W(DATA_W)) u_neg (
      .din  (scaled),
      .dout (negated)
   );

   always_comb begin
      if (mode1.mute)
         result = '0;
      else if (mode1.invert)
         result = negated;
      else
         result = scaled;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= v1;
         if (v1)
            out_data <= result;
      end
   end
endmodule

// File: rtl/stereo_attenuator.sv
module stereo_attenuator
   import gain_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int VOL_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_vol_we,
   input  logic [VOL_W-1:0]  cfg_vol,
   input  logic              cfg_mode_we,
   input  logic              cfg_invert,
   input  logic              cfg_mute,
   input  logic              l_valid,
   input  logic [DATA_W-1:0] l_data,
   input  logic              r_valid,
   input  logic [DATA_W-1:0] r_data,
   output logic              l_out_valid,
   output logic [DATA_W-1:0] l_out,
   output logic              r_out_valid,
   output logic [DATA_W-1:0] r_out
);
   localparam int NUM_CH = 2;

   if (DATA_W < 8)  begin : g_bad_data  $error("DATA_W must be at least 8");  end
   if (VOL_W < 2)   begin : g_bad_vol   $error("VOL_W must be at least 2");   end
   if (VOL_W >= DATA_W + 8) begin : g_bad_ratio $error("VOL_W too wide for DATA_W"); end

   logic [NUM_CH-1:0][VOL_W-1:0]  vol_q;
   mode_t                         mode_q;
   mode_t                         mode_din;
   logic [NUM_CH-1:0]             in_v, out_v;
   logic [NUM_CH-1:0][DATA_W-1:0] in_d, out_d;

   assign mode_din = '{invert: cfg_invert, mute: cfg_mute};

   gain_cfg_regs #(.VOL_W(VOL_W), .NUM_CH(NUM_CH)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .vol_we   (cfg_vol_we),
      .vol_din  (cfg_vol),
      .mode_we  (cfg_mode_we),
      .mode_din (mode_din),
      .vol_q    (vol_q),
      .mode_q   (mode_q)
   );

   assign in_v = {r_valid, l_valid};
   assign in_d = {r_data, l_data};

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      gain_lane #(.DATA_W(DATA_W), .VOL_W(VOL_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (in_v[c]),
         .in_data   (in_d[c]),
         .vol       (vol_q[c]),
         .mode      (mode_q),
         .out_valid (out_v[c]),
         .out_data  (out_d[c])
      );
   end

   assign l_out_valid = out_v[0];
   assign l_out       = out_d[0];
   assign r_out_valid = out_v[1];
   assign r_out       = out_d[1];
endmodule

// File: rtl/stereo_attenuator_chk.sv
module stereo_attenuator_chk #(
   parameter int DATA_W = 24,
   parameter int VOL_W  = 14
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   l_valid,
   input logic [DATA_W-1:0]      l_data,
   input logic                   r_valid,
   input logic [DATA_W-1:0]      r_data,
   input logic                   l_out_valid,
   input logic [DATA_W-1:0]      l_out,
   input logic                   r_out_valid,
   input logic [DATA_W-1:0]      r_out,
   input logic [1:0][VOL_W-1:0]  vol_q,
   input logic                   invert_q,
   input logic                   mute_q
);
   localparam logic [VOL_W-1:0]  FULL     = {VOL_W{1'b1}};
   localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

   a_r1_latency_left: assert property (@(posedge clk) disable iff (!rst_n)
      l_valid |-> ##2 l_out_valid);
   a_r1_idle_left: assert property (@(posedge clk) disable iff (!rst_n)
      !l_valid |-> ##2 !l_out_valid);
   a_r1_latency_right: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid |-> ##2 r_out_valid);
   a_r3_unity_left: assert property (@(posedge clk) disable iff (!rst_n)
      (l_valid && !mute_q && !invert_q && vol_q[0] == FULL) |-> ##2 (l_out == $past(l_data, 2)));
   a_r4_zero_right: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && vol_q[1] == '0) |-> ##2 (r_out == '0));
   a_r7_saturate_left: assert property (@(posedge clk) disable iff (!rst_n)
      (l_valid && !mute_q && invert_q && vol_q[0] == FULL && l_data == MOST_NEG) |-> ##2 (l_out == MOST_POS));
   a_r8_mute_left: assert property (@(posedge clk) disable iff (!rst_n)
      (l_valid && mute_q) |-> ##2 (l_out == '0));
   a_r8_mute_right: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && mute_q) |-> ##2 (r_out == '0));
endmodule

bind stereo_attenuator stereo_attenuator_chk #(.DATA_W(DATA_W), .VOL_W(VOL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .l_valid     (l_valid),
   .l_data      (l_data),
   .r_valid     (r_valid),
   .r_data      (r_data),
   .l_out_valid (l_out_valid),
   .l_out       (l_out),
   .r_out_valid (r_out_valid),
   .r_out       (r_out),
   .vol_q       (vol_q),
   .invert_q    (mode_q.invert),
   .mute_q      (mode_q.mute)
);

// File: tb/tb_stereo_attenuator.sv
module tb_stereo_attenuator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_vol_we = '0;
   logic [13:0] cfg_vol = '0;
   logic        cfg_mode_we = 1'b0;
   logic        cfg_invert = 1'b0;
   logic        cfg_mute = 1'b0;
   logic        l_valid = 1'b0, r_valid = 1'b0;
   logic [23:0] l_data = '0, r_data = '0;
   logic        l_out_valid, r_out_valid;
   logic [23:0] l_out, r_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   stereo_attenuator dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_vol_we(cfg_vol_we), .cfg_vol(cfg_vol),
      .cfg_mode_we(cfg_mode_we), .cfg_invert(cfg_invert), .cfg_mute(cfg_mute),
      .l_valid(l_valid), .l_data(l_data), .r_valid(r_valid), .r_data(r_data),
      .l_out_valid(l_out_valid), .l_out(l_out),
      .r_out_valid(r_out_valid), .r_out(r_out)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint model(longint x, int v, bit inv, bit mu);
      longint m, q;
      m = (v == 16383) ? 64'sd16384 : longint'(v);
      q = (x * m + 64'sd8192) >>> 14;
      if (mu) return 0;
      if (inv) q = (q == -64'sd8388608) ? 64'sd8388607 : -q;
      return q;
   endfunction

   function automatic longint sx(logic [23:0] d);
      return longint'($signed(d));
   endfunction

   function automatic string tag_of(int v, bit inv, bit mu);
      if (mu) return "R8";
      if (inv) return "R7";
      if (v == 16383) return "R3";
      if (v == 0) return "R4";
      return "R2";
   endfunction

   task automatic wr_vol(input logic [1:0] we, input int v);
      @(negedge clk);
      cfg_vol_we = we; cfg_vol = 14'(v);
      @(negedge clk);
      cfg_vol_we = '0;
   endtask

   task automatic wr_mode(input bit inv, input bit mu);
      @(negedge clk);
      cfg_mode_we = 1'b1; cfg_invert = inv; cfg_mute = mu;
      @(negedge clk);
      cfg_mode_we = 1'b0;
   endtask

   // drive both lanes at one negedge, check the outputs two edges later
   task automatic send(input longint lx, input longint rx, input longint le, input longint re,
                       input string lt, input string rt);
      @(negedge clk);
      l_data = lx[23:0]; r_data = rx[23:0]; l_valid = 1'b1; r_valid = 1'b1;
      @(negedge clk);
      l_valid = 1'b0; r_valid = 1'b0;
      chk("R1 left early", longint'(l_out_valid), 0);
      chk("R1 right early", longint'(r_out_valid), 0);
      @(negedge clk);
      chk("R1 left valid", longint'(l_out_valid), 1);
      chk("R1 right valid", longint'(r_out_valid), 1);
      chk(lt, sx(l_out), le);
      chk(rt, sx(r_out), re);
   endtask

   initial begin
      int vl[8] = '{0, 1, 2, 8191, 8192, 12000, 16382, 16383};
      longint dl[12] = '{0, 1, -1, 2, -2, 8388607, -8388608, 4096, -4097, 1234567, -7654321, 8191};

      repeat (3) @(negedge clk);
      chk("R6 reset left valid", longint'(l_out_valid), 0);
      chk("R6 reset right valid", longint'(r_out_valid), 0);
      rst_n = 1'b1;

      // R6: default full scale, no flip, no mute
      send(1000, -1000, 1000, -1000, "R6 left default", "R6 right default");
      send(-8388608, 8388607, -8388608, 8388607, "R6 left extreme", "R6 right extreme");

      // R5: left write leaves right alone, and vice versa
      wr_vol(2'b01, 0);
      send(5000, 5000, 0, 5000, "R5 left written", "R5 right untouched");
      wr_vol(2'b10, 8192);
      send(5000, 5001, 0, model(5001, 8192, 0, 0), "R5 left untouched", "R5 right written");

      // R1: lanes independent, a right-only sample leaves left idle
      @(negedge clk);
      r_data = 24'd300; r_valid = 1'b1;
      @(negedge clk);
      r_valid = 1'b0;
      @(negedge clk);
      chk("R1 left idle", longint'(l_out_valid), 0);
      chk("R1 right alone", longint'(r_out_valid), 1);
      chk("R2 right alone value", sx(r_out), model(300, 8192, 0, 0));
      @(negedge clk);
      chk("R1 right one cycle", longint'(r_out_valid), 0);

      // R9: volume write on the accepting edge applies to later samples only
      wr_vol(2'b01, 16383);
      @(negedge clk);
      l_data = 24'd1000; l_valid = 1'b1; cfg_vol_we = 2'b01; cfg_vol = 14'd0;
      @(negedge clk);
      l_valid = 1'b0; cfg_vol_we = '0;
      @(negedge clk);
      chk("R9 same-edge write old gain", sx(l_out), 1000);
      send(1000, 0, 0, 0, "R9 next sample new gain", "R9 right");

      // R9: mute written while a sample is in flight does not touch it
      wr_vol(2'b01, 8192);
      @(negedge clk);
      l_data = 24'd1001; l_valid = 1'b1;
      @(negedge clk);
      l_valid = 1'b0; cfg_mode_we = 1'b1; cfg_mute = 1'b1; cfg_invert = 1'b0;
      @(negedge clk);
      cfg_mode_we = 1'b0;
      chk("R9 in-flight unmuted", sx(l_out), model(1001, 8192, 0, 0));
      send(1001, 77, 0, 0, "R8 after write", "R8 after write right");

      // sweep: modes x volumes x data
      for (int md = 0; md < 4; md++) begin
         bit inv = md[0];
         bit mu  = md[1];
         wr_mode(inv, mu);
         for (int vi = 0; vi < 8; vi++) begin
            int lv = vl[vi];
            int rv = vl[7-vi];
            wr_vol(2'b01, lv);
            wr_vol(2'b10, rv);
            for (int di = 0; di < 12; di++) begin
               send(dl[di], dl[11-di], model(dl[di], lv, inv, mu), model(dl[11-di], rv, inv, mu),
                    tag_of(lv, inv, mu), tag_of(rv, inv, mu));
            end
         end
      end

      // R7: saturation on the most negative input at full scale
      wr_mode(1, 0);
      wr_vol(2'b11, 16383);
      send(-8388608, 8388607, 8388607, -8388607, "R7 saturate", "R7 negate max");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule